// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is a memory-mapped SPI master that runs one complete half-duplex command for each start request. Software first programs an opcode byte, a transmit byte count, a receive byte count and a chip-select number. It places any transmit payload in a 70-byte shared buffer, which the bus reaches one byte at a time through an address window. Software then sets the start bit. The engine drives the chosen chip select low and shifts out the opcode. It then sends the payload bytes from the buffer, clocks in the requested number of reply bytes, and writes each reply byte into the buffer directly after the bytes it sent.

A single internal pointer walks the buffer. The engine reads transmit bytes at the pointer and writes received bytes at the pointer, and the pointer moves on by one per byte. Software normally zeroes the pointer before each command. A status bit stays high from the cycle after the start until the chip select has been released. SPI timing is mode 0, bytes go most significant bit first, and SCLK runs at the system clock divided by the even parameter `CLK_DIV` (at least 2).

Top module: `spi_cmd_engine`

## Requirements
- R1: Under reset and right after it, all chip selects read high, SCLK and MOSI are low, and the status word at 0x4C reads 0.
- R2: Writing a word with bit 7 set to offset 0x47 while idle starts a command. Status bit 31 at 0x4C reads 1 from the next cycle until the command ends. Offset 0x47 always reads 0.
- R3: Bits 1:0 written at 0x1D pick which output of `spi_cs_n` goes low. Only that one goes low, and it falls exactly once per command and stays low through every byte.
- R4: The byte at 0x45 is shifted out first, MSB first. SCLK idles low while no chip is selected, MOSI is sampled on the rising SCLK edge, and a command produces exactly 8 × (1 + tx + rx) rising edges.
- R5: After the opcode, the engine sends tx bytes (count at 0x48), taken from buffer positions pointer, pointer+1, and onwards.
- R6: The engine then clocks in rx bytes (count at 0x4B) from MISO and stores them at the buffer positions that follow the sent bytes. MOSI stays low during these bytes.
- R7: MISO is ignored during the opcode and transmit bytes. Buffer positions that were sent keep their contents.
- R8: Buffer byte i (0 ≤ i < 70) is read and written at offset 0x80 + i, in the low byte of the data word. Offsets past the buffer read 0.
- R9: A write to offset 0x00 with bit 20 set zeroes the pointer. Without that write, the next command continues from where the previous one stopped, wrapping from position 69 to 0.
- R10: While busy, a start request, a pointer-clear request and bus writes into the buffer window have no effect.
- R11: Busy drops only after the chip select has been high for at least one cycle.
- R12: With both counts zero, the command sends only the opcode (8 SCLK edges) and leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data (byte registers use bits 7:0) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
Two things are hard to reach from the ports. The first is the pointer wrapping past the end of the buffer. The second is bus traffic that arrives in the middle of a running command. The bench reaches the wrap by sending a 68-byte payload with no receive bytes. It then issues a second command without clearing the pointer, so that the next sent byte comes from position 68 and the reply bytes land at 69 and 0. For the mid-command case, one directed command sends a second start, a pointer clear and a buffer write while busy. The bench then confirms that the SCLK edge count, the reply placement and the whole buffer still match a single command taken in isolation.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam logic [7:0] ADDR_CTRL  = 8'h00;
    localparam logic [7:0] ADDR_CSSEL = 8'h1D;
    localparam logic [7:0] ADDR_OPC   = 8'h45;
    localparam logic [7:0] ADDR_GO    = 8'h47;
    localparam logic [7:0] ADDR_TXN   = 8'h48;
    localparam logic [7:0] ADDR_RXN   = 8'h4B;
    localparam logic [7:0] ADDR_STAT  = 8'h4C;
    localparam logic [7:0] ADDR_WIN   = 8'h80;

    localparam int CLR_BIT  = 20;
    localparam int GO_BIT   = 7;
    localparam int BUSY_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_TX,
        PH_RX
    } phase_t;

    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] tx_left;
        logic [7:0] rx_left;
    } cmd_t;

    // Advance a buffer position by one, wrapping at the buffer depth.
    function automatic int wrap_inc(input int pos, input int depth);
        return (pos + 1 >= depth) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       tx_en,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] dout
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active;
    logic          txen_q;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            txen_q <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            sh_tx  <= '0;
            sh_rx  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                txen_q <= tx_en;
                sh_tx  <= din;
                cnt    <= '0;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        sh_rx <= {sh_rx[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            sh_tx <= {sh_tx[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign mosi = active && txen_q && sh_tx[7];
    assign dout = sh_rx;

    a_r4_clock_rests_low: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |-> !sclk);

endmodule

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
    parameter int BUF_BYTES = 70,
    localparam int PW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          bus_we,
    input  logic [PW-1:0] bus_idx,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          eng_we,
    input  logic [PW-1:0] eng_idx,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);
    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (eng_we)
            mem[eng_idx] <= eng_wdata;
        else if (bus_we)
            mem[bus_idx] <= bus_wdata;
    end

    assign bus_rdata = mem[bus_idx];
    assign eng_rdata = mem[eng_idx];

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES = 70,
    parameter int NUM_CS    = 4,
    localparam int PW   = $clog2(BUF_BYTES),
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            clr_ptr,
    input  logic [7:0]      opcode,
    input  logic [7:0]      tx_cnt,
    input  logic [7:0]      rx_cnt,
    input  logic [CS_W-1:0] cs_sel,
    output logic            busy,
    output logic            cs_act,
    output logic [CS_W-1:0] cs_idx,
    output logic [PW-1:0]   buf_idx,
    input  logic [7:0]      buf_rdata,
    output logic            buf_we,
    output logic [7:0]      buf_wdata,
    output logic            sh_start,
    output logic [7:0]      sh_din,
    output logic            sh_txen,
    input  logic            sh_done,
    input  logic [7:0]      sh_dout
);
    seq_state_t      state;
    phase_t          phase;
    cmd_t            cmd;
    logic [PW-1:0]   ptr;
    logic [CS_W-1:0] cs_q;
    logic            more_tx;
    logic            more_rx;

    always_comb begin
        more_tx = (phase == PH_TX) ? (cmd.tx_left > 8'd1) : (cmd.tx_left != 8'd0);
        more_rx = (phase == PH_RX) ? (cmd.rx_left > 8'd1) : (cmd.rx_left != 8'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_OPC;
            cmd   <= '0;
            ptr   <= '0;
            cs_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (clr_ptr)
                        ptr <= '0;
                    if (go) begin
                        cmd.opc     <= opcode;
                        cmd.tx_left <= tx_cnt;
                        cmd.rx_left <= rx_cnt;
                        cs_q        <= cs_sel;
                        phase       <= PH_OPC;
                        state       <= ST_LOAD;
                    end
                end
                ST_LOAD: state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (phase == PH_TX) begin
                            ptr         <= PW'(wrap_inc(int'(ptr), BUF_BYTES));
                            cmd.tx_left <= cmd.tx_left - 8'd1;
                        end else if (phase == PH_RX) begin
                            ptr         <= PW'(wrap_inc(int'(ptr), BUF_BYTES));
                            cmd.rx_left <= cmd.rx_left - 8'd1;
                        end
                        if (phase != PH_RX && more_tx) begin
                            phase <= PH_TX;
                            state <= ST_LOAD;
                        end else if (more_rx) begin
                            phase <= PH_RX;
                            state <= ST_LOAD;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign cs_act    = (state == ST_LOAD) || (state == ST_SHIFT);
    assign cs_idx    = cs_q;
    assign buf_idx   = ptr;
    assign buf_we    = (state == ST_SHIFT) && sh_done && (phase == PH_RX);
    assign buf_wdata = sh_dout;
    assign sh_start  = (state == ST_LOAD);
    assign sh_txen   = (phase != PH_RX);
    assign sh_din    = (phase == PH_OPC) ? cmd.opc :
                       (phase == PH_TX)  ? buf_rdata : 8'h00;

    a_r2_busy_follows_go: assert property (@(posedge clk) disable iff (rst)
        (!busy && go) |=> busy);

    a_r10_go_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && go) |=> ($stable(cmd.opc) && $stable(cs_q)));

    a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < BUF_BYTES);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int BUF_BYTES = 70,
    parameter int NUM_CS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int PW   = $clog2(BUF_BYTES);
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [7:0]      opc_q, txn_q, rxn_q;
    logic [CS_W-1:0] cs_sel_q;
    logic            go, clr;
    logic            busy, cs_act;
    logic [CS_W-1:0] cs_idx;
    logic [7:0]      win_off;
    logic            in_win;
    logic [7:0]      win_rdata;
    logic [PW-1:0]   eng_idx;
    logic [7:0]      eng_rdata, eng_wdata;
    logic            eng_we;
    logic            sh_start, sh_txen, sh_done;
    logic [7:0]      sh_din, sh_dout;

    assign win_off = bus_addr - ADDR_WIN;
    assign in_win  = bus_addr[7] && (win_off < 8'(BUF_BYTES));
    assign go      = bus_wr && (bus_addr == ADDR_GO) && bus_wdata[GO_BIT];
    assign clr     = bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q    <= '0;
            txn_q    <= '0;
            rxn_q    <= '0;
            cs_sel_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_OPC:   opc_q    <= bus_wdata[7:0];
                ADDR_TXN:   txn_q    <= bus_wdata[7:0];
                ADDR_RXN:   rxn_q    <= bus_wdata[7:0];
                ADDR_CSSEL: cs_sel_q <= bus_wdata[CS_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            bus_rdata[7:0] = win_rdata;
        end else begin
            case (bus_addr)
                ADDR_CSSEL: bus_rdata[CS_W-1:0] = cs_sel_q;
                ADDR_OPC:   bus_rdata[7:0]      = opc_q;
                ADDR_TXN:   bus_rdata[7:0]      = txn_q;
                ADDR_RXN:   bus_rdata[7:0]      = rxn_q;
                ADDR_STAT:  bus_rdata[BUSY_BIT] = busy;
                default: ;
            endcase
        end
    end

    spi_cmd_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk       (clk),
        .bus_we    (bus_wr && in_win && !busy),
        .bus_idx   (PW'(win_off)),
        .bus_wdata (bus_wdata[7:0]),
        .bus_rdata (win_rdata),
        .eng_we    (eng_we),
        .eng_idx   (eng_idx),
        .eng_wdata (eng_wdata),
        .eng_rdata (eng_rdata)
    );

    spi_cmd_seq #(.BUF_BYTES(BUF_BYTES), .NUM_CS(NUM_CS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .clr_ptr   (clr),
        .opcode    (opc_q),
        .tx_cnt    (txn_q),
        .rx_cnt    (rxn_q),
        .cs_sel    (cs_sel_q),
        .busy      (busy),
        .cs_act    (cs_act),
        .cs_idx    (cs_idx),
        .buf_idx   (eng_idx),
        .buf_rdata (eng_rdata),
        .buf_we    (eng_we),
        .buf_wdata (eng_wdata),
        .sh_start  (sh_start),
        .sh_din    (sh_din),
        .sh_txen   (sh_txen),
        .sh_done   (sh_done),
        .sh_dout   (sh_dout)
    );

    spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .din   (sh_din),
        .tx_en (sh_txen),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .dout  (sh_dout)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs_n[g] = !(cs_act && (cs_idx == CS_W'(g)));
    end

    a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    a_r4_sclk_low_unselected: assert property (@(posedge clk) disable iff (rst)
        (&spi_cs_n) |-> !spi_sclk);

    a_r11_cs_off_before_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ((&spi_cs_n) && $past(&spi_cs_n)));

endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
    import spi_cmd_pkg::*;

    localparam int DIV  = 4;
    localparam int NBUF = 70;
    localparam int NCS  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, miso;
    logic [NCS-1:0] cs_n;

    always #4 clk = ~clk;

    spi_cmd_engine #(.CLK_DIV(DIV), .BUF_BYTES(NBUF), .NUM_CS(NCS)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
        .spi_cs_n(cs_n)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] model_buf [NBUF];
    int model_ptr = 0;

    // Device model: reply bytes, captured MOSI bytes, edge counter.
    logic [7:0]  resp [128];
    logic [7:0]  mlog [128];
    logic [15:0] bitcnt = '0;
    int   cur_tx = 0;
    int   cur_cs = 0;
    logic mosi_rx_bad = 1'b0;
    logic cs_bad = 1'b0;
    int   cs_edges = 0;
    logic cs_prev_act = 1'b0;

    always_comb miso = resp[bitcnt[9:3]][3'd7 - bitcnt[2:0]];

    always @(posedge sclk) begin
        mlog[bitcnt[9:3]] = {mlog[bitcnt[9:3]][6:0], mosi};
        if (int'(bitcnt) >= 8 * (1 + cur_tx) && mosi) mosi_rx_bad = 1'b1;
        bitcnt = bitcnt + 16'd1;
    end

    always @(negedge clk) begin
        if (cs_n != 4'hF) begin
            if (cs_n != ~(4'b0001 << cur_cs)) cs_bad = 1'b1;
            if (!cs_prev_act) cs_edges = cs_edges + 1;
        end
        cs_prev_act = (cs_n != 4'hF);
    end

    function automatic int wrap(input int p);
        return p % NBUF;
    endfunction

    function automatic int exp_edges(input int tx, input int rx);
        return 8 * (1 + tx + rx);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic load_buf(input int idx, input logic [7:0] v);
        bus_write(ADDR_WIN + 8'(idx), {24'b0, v});
        model_buf[idx] = v;
    endtask

    task automatic check_buffer(input string tag);
        logic [31:0] d;
        int miss = 0;
        int first = -1;
        int act = 0;
        for (int i = 0; i < NBUF; i++) begin
            @(negedge clk);
            bus_read(ADDR_WIN + 8'(i), d);
            if (d[7:0] !== model_buf[i]) begin
                if (first < 0) begin first = i; act = int'(d[7:0]); end
                miss++;
            end
        end
        if (first < 0) check(1'b1, tag, "buffer contents", 0, 0);
        else check(1'b0, tag, $sformatf("buffer byte %0d", first), act, int'(model_buf[first]));
    endtask

    task automatic run_cmd(input logic [7:0] op, input int tx, input int rx,
                           input int cs, input bit clr, input bit poke);
        logic [31:0] d;
        logic prev_act;
        logic late;
        int miss;
        if (clr) begin
            bus_write(ADDR_CTRL, 32'h1 << CLR_BIT);
            model_ptr = 0;
        end
        bus_write(ADDR_OPC, {24'b0, op});
        bus_write(ADDR_TXN, 32'(tx));
        bus_write(ADDR_RXN, 32'(rx));
        bus_write(ADDR_CSSEL, 32'(cs));
        for (int k = 0; k < 128; k++) begin
            resp[k] = 8'($urandom);
            mlog[k] = 8'h00;
        end
        bitcnt = '0; cur_tx = tx; cur_cs = cs;
        mosi_rx_bad = 1'b0; cs_bad = 1'b0; cs_edges = 0;
        bus_write(ADDR_GO, 32'h80);
        bus_read(ADDR_STAT, d);
        check(d[31] == 1'b1, "R2", "busy after start", int'(d[31]), 1);
        bus_read(ADDR_GO, d);
        check(d == 32'h0, "R2", "start bit readback", int'(d), 0);
        if (poke) begin
            // R10: start, pointer clear and buffer write while busy
            bus_write(ADDR_GO, 32'h80);
            bus_write(ADDR_CTRL, 32'h1 << CLR_BIT);
            bus_write(ADDR_WIN + 8'd60, 32'hEE);
        end
        prev_act = 1'b1;
        late = 1'b0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            bus_read(ADDR_STAT, d);
            if (!d[31]) begin
                if (prev_act) late = 1'b1;
                break;
            end
            prev_act = (cs_n != 4'hF);
        end
        check(int'(bitcnt) == exp_edges(tx, rx), "R4 R10", "sclk rising edges",
              int'(bitcnt), exp_edges(tx, rx));
        check(mlog[0] == op, "R4", "opcode on MOSI", int'(mlog[0]), int'(op));
        miss = 0;
        for (int i = 0; i < tx; i++)
            if (mlog[1 + i] != model_buf[wrap(model_ptr + i)]) miss++;
        check(miss == 0, "R5", "payload byte mismatches", miss, 0);
        check(!mosi_rx_bad, "R6", "MOSI high during receive", int'(mosi_rx_bad), 0);
        check(!cs_bad && cs_edges == 1, "R3", "select assertions", cs_edges, 1);
        check(!late, "R11", "busy cleared with select active", int'(late), 0);
        for (int j = 0; j < rx; j++)
            model_buf[wrap(model_ptr + tx + j)] = resp[1 + tx + j];
        model_ptr = wrap(model_ptr + tx + rx);
        check_buffer("R6 R7 R9 R10");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 128; k++) begin resp[k] = 8'h00; mlog[k] = 8'h00; end
        repeat (3) @(negedge clk);
        check(cs_n == 4'hF && !sclk && !mosi, "R1", "pins in reset",
              int'({cs_n, sclk, mosi}), 32'h3C);
        rst = 1'b0;
        @(negedge clk);
        bus_read(ADDR_STAT, d);
        check(d == 32'h0, "R1", "status after reset", int'(d), 0);
        check(cs_n == 4'hF, "R1", "selects after reset", int'(cs_n), 15);

        // R8: window access and edges of the window
        for (int i = 0; i < NBUF; i++) load_buf(i, 8'($urandom));
        @(negedge clk);
        bus_read(ADDR_WIN + 8'd69, d);
        check(d[7:0] == model_buf[69], "R8", "last window byte", int'(d[7:0]), int'(model_buf[69]));
        bus_read(ADDR_WIN + 8'd70, d);
        check(d == 32'h0, "R8", "past window", int'(d), 0);
        check_buffer("R8");

        // Directed command with mid-command bus traffic (R10)
        run_cmd(8'hA5, 3, 4, 2, 1'b1, 1'b1);
        // R12: opcode only
        run_cmd(8'h3C, 0, 0, 0, 1'b1, 1'b0);
        check(bitcnt == 16'd8, "R12", "opcode-only edges", int'(bitcnt), 8);
        // Receive only
        run_cmd(8'h0F, 0, 5, 3, 1'b1, 1'b0);
        // R9: continuation without clear, then wrap at the end
        run_cmd(8'h11, 2, 2, 1, 1'b1, 1'b0);
        run_cmd(8'h22, 1, 1, 0, 1'b0, 1'b0);
        run_cmd(8'h33, 68, 0, 2, 1'b1, 1'b0);
        run_cmd(8'h44, 1, 2, 1, 1'b0, 1'b0);
        // R7: full buffer of replies right after a full payload
        run_cmd(8'h55, 35, 35, 3, 1'b1, 1'b0);

        for (int it = 0; it < 14; it++) begin
            int tx = int'($urandom % 41);
            int rx = int'($urandom % (NBUF - tx + 1));
            for (int k = 0; k < 4; k++) load_buf(int'($urandom % NBUF), 8'($urandom));
            run_cmd(8'($urandom), tx, rx, int'($urandom % NCS), (it % 4) != 3, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule